// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This block is a bus-master DMA engine that moves a local buffer of known byte length to or from a set of memory regions. The regions are named by a table of 8-byte descriptors in memory. On a start pulse the engine captures the table base, the buffer length and the transfer direction. It then alternates between fetching descriptors and moving data, and stops when the buffer has drained or when the table runs out. Descriptor reads and data moves share one request/acknowledge memory port. A data request carries the region address and a byte count, and the local side advances its buffer index by the same count.

Each descriptor holds two little-endian 32-bit words. The word at the lower address is the region base and the following word holds the size and flags. Bit 31 marks the final entry. Bits 15..1 give an even byte count, and a count of zero stands for 64 KiB. As a safeguard the walk also ends once the descriptor pointer has moved one 4 KiB page past the base. When the table ends with buffer bytes still left, the status output reports an incomplete transfer.

The controller has six states. IDLE waits for start (IDLE→EVAL). EVAL picks the next action: EVAL→FINISH when the buffer is empty or the table is exhausted, EVAL→FETCH_ADDR when the current region is used up, and EVAL→MOVE otherwise. FETCH_ADDR reads the region base (FETCH_ADDR→FETCH_SIZE on acknowledge). FETCH_SIZE reads the size word (FETCH_SIZE→EVAL on acknowledge). MOVE issues one data step (MOVE→EVAL on acknowledge). FINISH pulses done for one cycle (FINISH→IDLE).

Top module: `sg_walker`

## Requirements
- R1: A start pulse in IDLE captures the table base with its two low bits forced to zero, and clears the buffer index and the status. The first descriptor is read at that aligned base, and the second word at base+4.
- R2: Descriptor fetches are two 4-byte reads with the write flag low. The first returns the region address and the second the size word. The region length is the size word ANDed with 0xFFFE, so bit 0 is ignored.
- R3: A masked length of zero gives a region of 65536 bytes.
- R4: Once a region whose size word has bit 31 set is used up, no further descriptor is read. If buffer bytes remain, done is raised with the incomplete flag at 1.
- R5: No descriptor is read once the pointer is 4096 or more bytes past the aligned base. If buffer bytes remain, the walk ends with the incomplete flag at 1.
- R6: Each data request moves min(buffer bytes left, region bytes left) bytes at the current region address. The buffer index output advances by that count.
- R7: When the buffer drains, done is raised with the incomplete flag at 0 and no further descriptor is read, even if region bytes remain.
- R8: Data requests carry the write flag equal to the direction captured at start (1 = device to memory).
- R9: A request holds its address, length and write flag unchanged until it is acknowledged.
- R10: A start pulse while the engine is busy has no effect on the walk in progress.
- R11: A zero buffer length finishes with no memory request and the incomplete flag at 0.
- R12: After reset the engine is idle with no request, done low, incomplete low and buffer index 0. Done lasts exactly one cycle and is followed by idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, honoured in IDLE only |
| table_base_i | input | ADDR_W | Descriptor table base address |
| buf_len_i | input | BUF_W | Local buffer byte length |
| to_mem_i | input | 1 | 1 = device to memory, 0 = memory to device |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a memory write |
| mem_addr_o | output | ADDR_W | Request address |
| mem_len_o | output | LEN_W | Request byte count |
| mem_ack_i | input | 1 | Request accepted (read data valid) |
| mem_rdata_i | input | 32 | Read data for descriptor fetches |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| incomplete_o | output | 1 | Table ended before the buffer drained |
| buf_idx_o | output | BUF_W | Local buffer bytes moved so far |

## Verification
A request appears on the port in the cycle after EVAL decides on it, and it stays there until the acknowledge edge. After that edge the engine re-enters EVAL and presents the next request one cycle later. The bench answers each request at a falling edge after a random delay of 0 to 2 cycles, and records its address, length and direction at the moment it acknowledges. Done comes one cycle after the final EVAL. The bench samples it, together with the incomplete flag and the buffer index, at the falling edge where done is high. It then compares the whole recorded sequence with a walk computed by a bench function from the requirements.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_FETCH_ADDR,
        ST_FETCH_SIZE,
        ST_MOVE,
        ST_FINISH
    } sgw_state_e;

    localparam int DESC_WORD_BYTES = 4;
    localparam int MAX_REGION      = 65536;

endpackage

// File: rtl/sgw_desc_decode.sv
module sgw_desc_decode #(
    parameter int LEN_W = 17
) (
    input  logic [31:0]      size_word,
    output logic [LEN_W-1:0] region_len,
    output logic             last_entry
);
    import sgw_pkg::*;

    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(MAX_REGION);

    logic [15:0] masked;
    logic        unused_bits;

    assign masked      = {size_word[15:1], 1'b0};
    assign unused_bits = ^{size_word[30:16], size_word[0]};

    always_comb begin
        if (masked == 16'd0) begin
            region_len = FULL_LEN;
        end else begin
            region_len = LEN_W'(masked);
        end
        last_entry = size_word[31];
    end

endmodule

// File: rtl/sgw_step_sel.sv
module sgw_step_sel #(
    parameter int BUF_W = 20,
    parameter int LEN_W = 17
) (
    input  logic [BUF_W-1:0] buf_left,
    input  logic [LEN_W-1:0] reg_left,
    output logic [LEN_W-1:0] step
);
    localparam int CMP_W = (BUF_W > LEN_W) ? BUF_W : LEN_W;

    logic [CMP_W-1:0] buf_ext;
    logic [CMP_W-1:0] reg_ext;

    assign buf_ext = CMP_W'(buf_left);
    assign reg_ext = CMP_W'(reg_left);

    always_comb begin
        if (buf_ext < reg_ext) begin
            step = LEN_W'(buf_ext);
        end else begin
            step = reg_left;
        end
    end

endmodule

// File: rtl/sgw_guard.sv
module sgw_guard #(
    parameter int ADDR_W = 32,
    parameter int SPAN   = 4096
) (
    input  logic [ADDR_W-1:0] ptr,
    input  logic [ADDR_W-1:0] base,
    output logic              expired
);
    localparam logic [ADDR_W-1:0] SPAN_V = ADDR_W'(SPAN);

    logic [ADDR_W-1:0] offset;

    assign offset  = ptr - base;
    assign expired = (offset >= SPAN_V);

endmodule

// File: rtl/sg_walker.sv
module sg_walker #(
    parameter int ADDR_W    = 32,
    parameter int BUF_W     = 20,
    parameter int LEN_W     = 17,
    parameter int PAGE_SPAN = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] table_base_i,
    input  logic [BUF_W-1:0]  buf_len_i,
    input  logic              to_mem_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [LEN_W-1:0]  mem_len_o,
    input  logic              mem_ack_i,
    input  logic [31:0]       mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              incomplete_o,
    output logic [BUF_W-1:0]  buf_idx_o
);
    import sgw_pkg::*;

    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(DESC_WORD_BYTES);
    localparam logic [LEN_W-1:0]  WORD_LEN  = LEN_W'(DESC_WORD_BYTES);

    sgw_state_e state_q, state_d;

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] reg_addr_q;
    logic [LEN_W-1:0]  reg_left_q;
    logic              last_q;
    logic [BUF_W-1:0]  buf_left_q;
    logic [BUF_W-1:0]  idx_q;
    logic              dir_q;
    logic              incomplete_q;

    logic [LEN_W-1:0]  dec_len;
    logic              dec_last;
    logic [LEN_W-1:0]  step;
    logic              page_out;
    logic              buf_empty;
    logic              region_empty;
    logic              table_end;

    sgw_desc_decode #(.LEN_W(LEN_W)) u_decode (
        .size_word  (mem_rdata_i),
        .region_len (dec_len),
        .last_entry (dec_last)
    );

    sgw_step_sel #(.BUF_W(BUF_W), .LEN_W(LEN_W)) u_step (
        .buf_left (buf_left_q),
        .reg_left (reg_left_q),
        .step     (step)
    );

    sgw_guard #(.ADDR_W(ADDR_W), .SPAN(PAGE_SPAN)) u_guard (
        .ptr     (ptr_q),
        .base    (base_q),
        .expired (page_out)
    );

    assign buf_empty    = (buf_left_q == '0);
    assign region_empty = (reg_left_q == '0);
    assign table_end    = last_q || page_out;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_EVAL;
            end
            ST_EVAL: begin
                if (buf_empty) begin
                    state_d = ST_FINISH;
                end else if (region_empty) begin
                    state_d = table_end ? ST_FINISH : ST_FETCH_ADDR;
                end else begin
                    state_d = ST_MOVE;
                end
            end
            ST_FETCH_ADDR: begin
                if (mem_ack_i) state_d = ST_FETCH_SIZE;
            end
            ST_FETCH_SIZE: begin
                if (mem_ack_i) state_d = ST_EVAL;
            end
            ST_MOVE: begin
                if (mem_ack_i) state_d = ST_EVAL;
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q       <= '0;
            ptr_q        <= '0;
            reg_addr_q   <= '0;
            reg_left_q   <= '0;
            last_q       <= 1'b0;
            buf_left_q   <= '0;
            idx_q        <= '0;
            dir_q        <= 1'b0;
            incomplete_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        base_q       <= {table_base_i[ADDR_W-1:2], 2'b00};
                        ptr_q        <= {table_base_i[ADDR_W-1:2], 2'b00};
                        reg_addr_q   <= '0;
                        reg_left_q   <= '0;
                        last_q       <= 1'b0;
                        buf_left_q   <= buf_len_i;
                        idx_q        <= '0;
                        dir_q        <= to_mem_i;
                        incomplete_q <= 1'b0;
                    end
                end
                ST_EVAL: begin
                    if (!buf_empty && region_empty && table_end) begin
                        incomplete_q <= 1'b1;
                    end
                end
                ST_FETCH_ADDR: begin
                    if (mem_ack_i) begin
                        reg_addr_q <= mem_rdata_i[ADDR_W-1:0];
                        ptr_q      <= ptr_q + WORD_STEP;
                    end
                end
                ST_FETCH_SIZE: begin
                    if (mem_ack_i) begin
                        reg_left_q <= dec_len;
                        last_q     <= dec_last;
                        ptr_q      <= ptr_q + WORD_STEP;
                    end
                end
                ST_MOVE: begin
                    if (mem_ack_i) begin
                        reg_addr_q <= reg_addr_q + ADDR_W'(step);
                        reg_left_q <= reg_left_q - step;
                        buf_left_q <= buf_left_q - BUF_W'(step);
                        idx_q      <= idx_q + BUF_W'(step);
                    end
                end
                ST_FINISH: begin
                end
                default: begin
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_req_o  = 1'b0;
        mem_we_o   = 1'b0;
        mem_addr_o = '0;
        mem_len_o  = '0;
        done_o     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_EVAL: begin
            end
            ST_FETCH_ADDR, ST_FETCH_SIZE: begin
                mem_req_o  = 1'b1;
                mem_addr_o = ptr_q;
                mem_len_o  = WORD_LEN;
            end
            ST_MOVE: begin
                mem_req_o  = 1'b1;
                mem_we_o   = dir_q;
                mem_addr_o = reg_addr_q;
                mem_len_o  = step;
            end
            ST_FINISH: begin
                done_o = 1'b1;
            end
            default: begin
            end
        endcase
        busy_o       = (state_q != ST_IDLE);
        incomplete_o = incomplete_q;
        buf_idx_o    = idx_q;
    end

endmodule

// File: rtl/sgw_chk.sv
module sgw_chk #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [LEN_W-1:0]  mem_len_o,
    input logic              mem_ack_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              incomplete_o
);

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
                                       && $stable(mem_len_o) && $stable(mem_we_o)));

    // R6
    step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_len_o != '0 && mem_len_o <= LEN_W'(65536)));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_req_o && !done_o));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R7
    done_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mem_req_o);

    // R4
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !$past(busy_o)) |-> $stable(incomplete_o));

endmodule

bind sg_walker sgw_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/sim_sg_walker.sv
module sim_sg_walker;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int BUF_W      = 20;
    localparam int LEN_W      = 17;
    localparam int TBL_N      = 600;
    localparam int OBS_N      = 1100;
    localparam int WATCHDOG   = 150000;
    localparam logic [31:0] TBL_LO = 32'h0010_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] table_base_i = '0;
    logic [BUF_W-1:0]  buf_len_i = '0;
    logic              to_mem_i = 1'b0;
    logic              mem_req_o;
    logic              mem_we_o;
    logic [ADDR_W-1:0] mem_addr_o;
    logic [LEN_W-1:0]  mem_len_o;
    logic              mem_ack_i = 1'b0;
    logic [31:0]       mem_rdata_i = '0;
    logic              busy_o;
    logic              done_o;
    logic              incomplete_o;
    logic [BUF_W-1:0]  buf_idx_o;

    sg_walker #(.ADDR_W(ADDR_W), .BUF_W(BUF_W), .LEN_W(LEN_W)) u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    logic [31:0] tbl_addr [TBL_N];
    logic [31:0] tbl_size [TBL_N];
    logic [31:0] cur_base;

    int obs_n, obs_fetch, fetch_bad;
    int obs_addr [OBS_N];
    int obs_len  [OBS_N];
    int obs_we   [OBS_N];

    int exp_n, exp_fetch, exp_inc, exp_total;
    int exp_addr [OBS_N];
    int exp_len  [OBS_N];

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Watchdog
    initial begin
        forever begin
            @(negedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
                $finish;
            end
        end
    end

    // Memory responder
    initial begin
        bit pending;
        int wait_n;
        int off;
        pending = 0;
        wait_n  = 0;
        forever begin
            @(negedge clk);
            if (mem_ack_i) begin
                mem_ack_i = 1'b0;
                pending   = 0;
            end else if (mem_req_o) begin
                if (!pending) begin
                    pending = 1;
                    wait_n  = $urandom_range(0, 2);
                end
                if (wait_n == 0) begin
                    if (mem_addr_o >= TBL_LO && mem_addr_o < TBL_LO + 32'h0001_0000) begin
                        // R1 R2: fetch order and shape
                        if (mem_addr_o != cur_base + 32'(4 * obs_fetch) || mem_we_o
                            || mem_len_o != 17'd4) fetch_bad++;
                        off = int'(mem_addr_o - cur_base);
                        if (off >= 0 && off / 8 < TBL_N)
                            mem_rdata_i = ((off / 4) % 2 == 0) ? tbl_addr[off/8] : tbl_size[off/8];
                        else
                            mem_rdata_i = '0;
                        obs_fetch++;
                    end else begin
                        if (obs_n < OBS_N) begin
                            obs_addr[obs_n] = int'(mem_addr_o);
                            obs_len[obs_n]  = int'(mem_len_o);
                            obs_we[obs_n]   = int'(mem_we_o);
                        end
                        obs_n++;
                        mem_rdata_i = '0;
                    end
                    mem_ack_i = 1'b1;
                end else begin
                    wait_n--;
                end
            end
        end
    end

    // Reference walk computed from the requirements
    task automatic model_walk(input int blen);
        int left, off, rl, ra, step, sz;
        bit last;
        left = blen; off = 0; rl = 0; ra = 0; last = 0;
        exp_n = 0; exp_fetch = 0; exp_inc = 0; exp_total = 0;
        while (left > 0) begin
            if (rl == 0) begin
                if (last || off >= 4096) begin
                    exp_inc = 1;
                    break;
                end
                ra   = int'(tbl_addr[off/8]);
                sz   = int'(tbl_size[off/8]);
                rl   = sz & 32'hFFFE;
                if (rl == 0) rl = 65536;
                last = tbl_size[off/8][31];
                off += 8;
                exp_fetch += 2;
            end
            step = (left < rl) ? left : rl;
            if (exp_n < OBS_N) begin
                exp_addr[exp_n] = ra;
                exp_len[exp_n]  = step;
            end
            exp_n++;
            ra += step; rl -= step; left -= step; exp_total += step;
        end
    endtask

    task automatic run_case(input string tag, input logic [31:0] base, input int blen,
                            input bit dir, input bit poke_busy);
        int guard_n;
        int bad;
        cur_base  = {base[31:2], 2'b00};
        obs_n     = 0;
        obs_fetch = 0;
        fetch_bad = 0;
        model_walk(blen);
        @(negedge clk);
        table_base_i = base;
        buf_len_i    = BUF_W'(blen);
        to_mem_i     = dir;
        start_i      = 1'b1;
        @(negedge clk);
        start_i      = 1'b0;
        table_base_i = TBL_LO + 32'h800;
        buf_len_i    = BUF_W'(7);
        to_mem_i     = ~dir;
        if (poke_busy) begin
            repeat (3) @(negedge clk);
            // R10: second start while busy
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        guard_n = 0;
        while (!done_o && guard_n < 140000) begin
            @(negedge clk);
            guard_n++;
        end
        chk(done_o == 1'b1, {tag, " R12 done seen"}, done_o, 1);
        chk(incomplete_o == exp_inc[0], {tag, " R4 R5 R7 incomplete flag"}, incomplete_o, exp_inc);
        chk(int'(buf_idx_o) == exp_total, {tag, " R6 buffer index"}, buf_idx_o, exp_total);
        chk(obs_n == exp_n, {tag, " R6 data request count"}, obs_n, exp_n);
        chk(obs_fetch == exp_fetch, {tag, " R4 R5 R7 descriptor reads"}, obs_fetch, exp_fetch);
        chk(fetch_bad == 0, {tag, " R1 R2 fetch address/shape"}, fetch_bad, 0);
        bad = 0;
        for (int i = 0; i < obs_n && i < exp_n && i < OBS_N; i++) begin
            if (obs_addr[i] != exp_addr[i] || obs_len[i] != exp_len[i] || obs_we[i] != int'(dir)) begin
                if (bad == 0)
                    $display("FAIL %s R6 R8 step %0d actual=%0h/%0d/%0d expected=%0h/%0d/%0d",
                             tag, i, obs_addr[i], obs_len[i], obs_we[i], exp_addr[i], exp_len[i], dir);
                bad++;
            end
        end
        n_checks++;
        if (bad != 0) n_fail++;
        @(negedge clk);
        chk(busy_o == 1'b0, {tag, " R12 idle after done"}, busy_o, 0);
    endtask

    function automatic void clear_table();
        for (int i = 0; i < TBL_N; i++) begin
            tbl_addr[i] = '0;
            tbl_size[i] = '0;
        end
    endfunction

    initial begin
        void'($urandom(32'd4242));
        clear_table();
        cur_base = TBL_LO;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(busy_o == 0 && mem_req_o == 0 && done_o == 0, "R12 reset idle", busy_o, 0);
        chk(incomplete_o == 0 && buf_idx_o == 0, "R12 reset status", buf_idx_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy_o == 0 && mem_req_o == 0, "R12 idle after reset", mem_req_o, 0);

        // Three regions, buffer matches exactly; odd size bit ignored (R2)
        clear_table();
        tbl_addr[0] = 32'h4000_0000; tbl_size[0] = 32'h0000_0064;
        tbl_addr[1] = 32'h4100_0000; tbl_size[1] = 32'h0000_00C9;
        tbl_addr[2] = 32'h4200_0000; tbl_size[2] = 32'h8000_012C;
        run_case("exact", TBL_LO, 600, 1'b1, 1'b0);
        // R7: buffer ends inside second region
        run_case("short", TBL_LO, 250, 1'b0, 1'b0);
        // R4: last entry reached first
        run_case("lastend", TBL_LO, 1000, 1'b1, 1'b0);
        // R10: start while busy
        run_case("restart", TBL_LO, 600, 1'b0, 1'b1);
        // R1: unaligned base
        run_case("unalign", TBL_LO + 32'h3, 600, 1'b1, 1'b0);
        // R11: empty buffer
        run_case("empty", TBL_LO, 0, 1'b1, 1'b0);

        // R3: zero length means 64 KiB
        clear_table();
        tbl_addr[0] = 32'h5000_0000; tbl_size[0] = 32'h0000_0001;
        tbl_addr[1] = 32'h5100_0000; tbl_size[1] = 32'h8000_0010;
        run_case("full64k", TBL_LO, 65540, 1'b1, 1'b0);

        // R5: page guard with no last marker
        clear_table();
        for (int i = 0; i < TBL_N; i++) begin
            tbl_addr[i] = 32'h6000_0000 + 32'(i * 16);
            tbl_size[i] = 32'h0000_0002;
        end
        run_case("pageguard", TBL_LO, 5000, 1'b0, 1'b0);

        // Random tables
        for (int t = 0; t < 20; t++) begin
            int nd, sum;
            clear_table();
            nd  = $urandom_range(1, 8);
            sum = 0;
            for (int i = 0; i < nd; i++) begin
                tbl_addr[i] = 32'h7000_0000 + 32'($urandom_range(0, 32'h00FF_FFFF));
                tbl_size[i] = 32'($urandom_range(1, 1023));
                sum += int'(tbl_size[i] & 32'hFFFE);
                if (tbl_size[i][15:1] == 0) sum += 65536;
            end
            if ($urandom_range(0, 3) != 0) tbl_size[nd-1][31] = 1'b1;
            else tbl_size[nd-1] = 32'h8000_0008;
            run_case($sformatf("rand%0d", t), TBL_LO + 32'(8 * $urandom_range(0, 16)),
                     $urandom_range(0, sum + 200), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule